// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives a single open-drain data line shared with one or more slave devices. Every bit is a time slot that the master starts by pulling the line low. The value of the bit is set by how long the line stays low. A host issues one command at a time: a bus reset, a byte write, or a byte read. A reset pulls the line low for a long interval. It then checks whether any device answers by holding the line low after the master lets go, and the result is kept as a presence flag. A write sends eight slots, each a short low pulse for a one or a long low pulse for a zero. A read sends eight short pulses and samples the line while a slave may be holding it low.

All timing counts whole microseconds. A prescaler divides the system clock by a parameter to make each microsecond. The durations of each pulse, each sample point and each slot are parameters in microseconds. A typical transaction is a reset, then a byte-level addressing command, then a function command, then its data. The host sequences these as separate commands.

The line input passes through a two-stage synchronizer before it is sampled. The output `bus_pull` enables an external open-drain driver.

Top module: `sw_bus_master`

## Requirements
- R1: After reset, `bus_pull`, `busy`, `done` and `presence` are 0 and `rx_data` is 0x00.
- R2: A reset command (`cmd_op` = 2'b00) holds `bus_pull` high for exactly 480 µs (480·CLK_PER_US cycles) and then releases the line. The command completes 960 µs after acceptance.
- R3: During a reset command the line is sampled 70 µs after release. `presence` becomes 1 if the line is low at that point and 0 if it is high. `presence` keeps this value until the next reset command.
- R4: A write command (`cmd_op` = 2'b01) sends `cmd_data` as eight slots, least significant bit first. A 1 bit pulls the line low for 6 µs and a 0 bit for 60 µs.
- R5: Each write or read slot lasts 61 µs from one rising edge of `bus_pull` to the next. This is a 60 µs slot plus 1 µs of recovery, so the line is released for at least 1 µs between slots.
- R6: A read command (`cmd_op` = 2'b10) runs eight slots, each pulling low for 6 µs. Each slot samples the line 15 µs after it starts; a high line gives a 1 bit and a low line a 0 bit. The first slot gives bit 0. The byte appears on `rx_data` when the command completes.
- R7: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle until completion. `cmd_valid` has no effect while `busy` is high.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low again. `rx_data` changes only in that cycle and only after a read.
- R9: `cmd_op` = 2'b11 is not accepted: `busy` and `bus_pull` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 reset, 01 write byte, 10 read byte, 11 unused |
| cmd_data | input | 8 | Byte to write |
| bus_in | input | 1 | Level of the shared line |
| bus_pull | output | 1 | 1 = drive the line low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A slave answered the last reset |
| rx_data | output | 8 | Byte from the last read |

## Verification
A presence answer or a zero read bit exists only when a second device pulls the line inside a narrow window. That window is set by the master's own pulse edges, so the ports alone cannot produce these cases. The bench therefore contains a responder model. It watches `bus_pull`, times its own pull from the master's release or from the start of a slot, and answers with randomly chosen presence and byte values. Commands are also injected in the middle of a transfer, to show that they leave the slot pattern untouched.

// File: rtl/sw_bus_master.sv
module sw_bus_master #(
  parameter int CLK_PER_US    = 250,
  parameter int RST_LOW_US    = 480,
  parameter int RST_WAIT_US   = 480,
  parameter int RST_SAMPLE_US = 70,
  parameter int SLOT_US       = 60,
  parameter int REC_US        = 1,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 60,
  parameter int RD_LOW_US     = 6,
  parameter int RD_SAMPLE_US  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       bus_in,
  output logic       bus_pull,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic [7:0] rx_data
);

  localparam int PW       = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int RST_LEN  = RST_LOW_US + RST_WAIT_US;
  localparam int SLOT_LEN = SLOT_US + REC_US;
  localparam int MAX_LEN  = (RST_LEN > SLOT_LEN) ? RST_LEN : SLOT_LEN;
  localparam int TW       = $clog2(MAX_LEN + 1);
  localparam int LW       = $clog2(RST_LEN * CLK_PER_US + 2);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  typedef enum logic [1:0] {IDLE, RESET, WRITE, READ} state_t;

  state_t        st;
  logic [PW-1:0] pre;
  logic [TW-1:0] t;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [1:0]    sync;
  logic          tick, slot_end, samp, accept;
  logic [TW-1:0] low_us, len_us, samp_us;

  assign tick     = (pre == PRE_LAST);
  assign busy     = (st != IDLE);
  assign accept   = !busy && cmd_valid && (cmd_op != 2'b11);
  assign bus_pull = busy && (t < low_us);
  assign slot_end = busy && tick && (t == len_us - TW'(1));
  assign samp     = tick && (st == RESET || st == READ) && (t == samp_us - TW'(1));

  always_comb begin
    low_us  = '0;
    len_us  = TW'(SLOT_LEN);
    samp_us = '0;
    case (st)
      RESET: begin
        low_us  = TW'(RST_LOW_US);
        len_us  = TW'(RST_LEN);
        samp_us = TW'(RST_LOW_US + RST_SAMPLE_US);
      end
      WRITE: low_us = sh[0] ? TW'(W1_LOW_US) : TW'(W0_LOW_US);
      READ: begin
        low_us  = TW'(RD_LOW_US);
        samp_us = TW'(RD_SAMPLE_US);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], bus_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      pre      <= '0;
      t        <= '0;
      bitn     <= '0;
      sh       <= '0;
      presence <= 1'b0;
      rx_data  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        pre  <= '0;
        t    <= '0;
        bitn <= '0;
        if (accept) begin
          case (cmd_op)
            2'b00:   st <= RESET;
            2'b01:   st <= WRITE;
            default: st <= READ;
          endcase
          if (cmd_op == 2'b01) sh <= cmd_data;
        end
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (samp) begin
          if (st == RESET) presence <= ~sync[1];
          else             sh <= {sync[1], sh[7:1]};
        end
        if (slot_end) begin
          t <= '0;
          if (st == RESET || bitn == 3'd7) begin
            st   <= IDLE;
            done <= 1'b1;
            if (st == READ) rx_data <= sh;
          end else begin
            bitn <= bitn + 3'd1;
            if (st == WRITE) sh <= {1'b0, sh[7:1]};
          end
        end else if (tick) begin
          t <= t + TW'(1);
        end
      end
    end
  end

  logic [LW-1:0] low_run, rel_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_run <= '0;
      rel_run <= '1;
    end else begin
      low_run <= bus_pull ? low_run + LW'(1) : '0;
      rel_run <= bus_pull ? '0 : ((rel_run == '1) ? rel_run : rel_run + LW'(1));
    end

  // R2 R4 R6
  pull_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_pull) |-> (int'(low_run) == RST_LOW_US * CLK_PER_US ||
                         int'(low_run) == W0_LOW_US * CLK_PER_US ||
                         int'(low_run) == W1_LOW_US * CLK_PER_US ||
                         int'(low_run) == RD_LOW_US * CLK_PER_US));
  // R5
  recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> int'(rel_run) >= REC_US * CLK_PER_US);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_data));
  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'b11) |=> busy);
  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 2'b11) |=> (!busy && !bus_pull));
  // R3
  presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(presence));

endmodule

// File: tb/sim_sw_bus_master.sv
`timescale 1ns/1ps
module sim_sw_bus_master;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic bus_in, bus_pull, busy, done, presence;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  sw_bus_master #(.CLK_PER_US(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .bus_in(bus_in), .bus_pull(bus_pull), .busy(busy),
    .done(done), .presence(presence), .rx_data(rx_data));

  int n_chk = 0, n_fail = 0;

  int         s_mode = 0;
  bit         s_present = 1'b0;
  logic [7:0] s_byte = 8'h00;
  int         s_idx = 0;
  bit         s_bit = 1'b1;
  logic       s_low = 1'b0;
  logic       s_pq = 1'b0;
  int         slot_t = 1000000, rel_t = 1000000;

  assign bus_in = ~bus_pull & ~s_low;

  always @(negedge clk) begin
    if (bus_pull && !s_pq) begin
      slot_t = 0;
      s_bit = s_byte[s_idx % 8];
      s_idx++;
    end else if (slot_t < 1000000) slot_t++;
    if (!bus_pull && s_pq) rel_t = 0;
    else if (rel_t < 1000000) rel_t++;
    s_pq = bus_pull;
    s_low = (s_mode == 1 && s_present && rel_t >= 15*N && rel_t < 135*N) ||
            (s_mode == 2 && !s_bit && slot_t < 30*N);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input logic [1:0] op, input logic [7:0] d, input int i);
    if (op == 2'b00) return 480*N;
    if (op == 2'b10) return 6*N;
    return d[i] ? 6*N : 60*N;
  endfunction

  function automatic int exp_total(input logic [1:0] op);
    return (op == 2'b00) ? 960*N : 8*61*N;
  endfunction

  int r_nlow, r_cyc;
  int r_wid[16];
  int r_rise[16];
  logic [7:0] exp_rx = 8'h00;
  bit exp_pres = 1'b0;

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input bit interfere);
    int cyc = 0, run = 0;
    logic prev = 1'b0;
    bit fin = 1'b0;
    r_nlow = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = 8'($urandom);
    while (!fin && cyc < 20000) begin
      if (bus_pull && !prev) begin
        if (r_nlow < 16) r_rise[r_nlow] = cyc;
        run = 0;
      end
      if (bus_pull) run++;
      if (!bus_pull && prev) begin
        if (r_nlow < 16) r_wid[r_nlow] = run;
        r_nlow++;
      end
      prev = bus_pull;
      if (done) fin = 1'b1;
      else begin
        if (interfere && cyc == 50) begin cmd_valid = 1'b1; cmd_op = 2'b00; end
        if (interfere && cyc == 51) cmd_valid = 1'b0;
        cyc++;
        @(negedge clk);
      end
    end
    r_cyc = cyc;
    chk(fin, "R8 done seen", cyc, exp_total(op));
    chk(r_cyc == exp_total(op), "R7 R2 command length", r_cyc, exp_total(op));
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] d, input bit interfere);
    logic [7:0] rx_before = rx_data;
    bit slots_ok = 1'b1, space_ok = 1'b1;
    run_cmd(op, d, interfere);
    if (op == 2'b00) begin
      chk(r_nlow == 1, "R2 one reset pulse", r_nlow, 1);
      chk(r_wid[0] == 480*N, "R2 reset low width", r_wid[0], 480*N);
      exp_pres = s_present;
      chk(presence == exp_pres, "R3 presence", presence, int'(exp_pres));
      chk(rx_data == rx_before, "R8 rx unchanged by reset", rx_data, rx_before);
    end else begin
      chk(r_nlow == 8, (op == 2'b01) ? "R4 eight slots" : "R6 eight slots", r_nlow, 8);
      for (int i = 0; i < 8 && i < r_nlow; i++) begin
        if (r_wid[i] != exp_low(op, d, i)) begin
          slots_ok = 1'b0;
          chk(1'b0, (op == 2'b01) ? "R4 slot width" : "R6 slot width", r_wid[i], exp_low(op, d, i));
        end
        if (r_rise[i] != i*61*N) begin
          space_ok = 1'b0;
          chk(1'b0, "R5 slot spacing", r_rise[i], i*61*N);
        end
      end
      chk(slots_ok, "R4 R6 slot widths", 0, 0);
      chk(space_ok, "R5 slot spacing", 0, 0);
      if (op == 2'b10) exp_rx = s_byte;
      chk(rx_data == exp_rx, (op == 2'b10) ? "R6 read byte" : "R8 rx unchanged by write", rx_data, exp_rx);
      chk(presence == exp_pres, "R3 presence held", presence, int'(exp_pres));
    end
  endtask

  initial begin
    bit bad = 1'b0;
    void'($urandom(32'd9137));
    repeat (5) @(negedge clk);
    chk(bus_pull == 0 && busy == 0 && done == 0 && presence == 0 && rx_data == 0,
        "R1 reset state", {busy, done, presence}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_pull == 0 && busy == 0, "R1 idle after reset", busy, 0);

    s_mode = 1; s_present = 1'b1; do_op(2'b00, 8'h00, 1'b0);
    s_mode = 1; s_present = 1'b0; do_op(2'b00, 8'h00, 1'b0);
    s_mode = 1; s_present = 1'b1; do_op(2'b00, 8'h00, 1'b1);
    s_mode = 0; do_op(2'b01, 8'h00, 1'b0);
    s_mode = 0; do_op(2'b01, 8'hFF, 1'b0);
    s_mode = 0; do_op(2'b01, 8'hA5, 1'b1);
    s_mode = 2; s_idx = 0; s_byte = 8'h00; do_op(2'b10, 8'h00, 1'b0);
    s_mode = 2; s_idx = 0; s_byte = 8'hFF; do_op(2'b10, 8'h00, 1'b0);
    s_mode = 2; s_idx = 0; s_byte = 8'h3C; do_op(2'b10, 8'h00, 1'b1);

    // R9 unused opcode
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (busy || bus_pull || done) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R9 opcode 11 ignored", bad, 0);

    for (int it = 0; it < 14; it++) begin
      logic [1:0] op = 2'($urandom_range(0, 2));
      logic [7:0] d = 8'($urandom);
      bit intf = 1'($urandom);
      s_mode = (op == 2'b00) ? 1 : (op == 2'b10) ? 2 : 0;
      s_present = 1'($urandom);
      s_byte = 8'($urandom);
      s_idx = 0;
      do_op(op, d, intf);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule